// File: doc/BRIEF.md
# Write Completion Status Reporter

This block builds the byte handed back on a read port of a non-volatile memory controller while an internally timed write or erase runs. The host cannot read ordinary array contents while that cycle runs. Instead it polls, and this block supports two ways of telling when the cycle is over. The first inverts the top data bit of the most recently loaded byte until the write ends. The second flips bit 6 on every poll until the busy period ends.

The write engine supplies a busy flag, an erase flag, and the address and data of the last byte it loaded. The array supplies the normal read data. The host raises a read request level, and each rising edge of that level produces exactly one registered response.

When the engine is idle, the response is the array byte unchanged. When the engine is busy, the response is a status byte. Bits 5 down to 0 of a status byte are always zero, so software can compare it against a fixed pattern.

Top module: `wcs_status_rdout`

## Requirements
- R1: After reset, `rd_vld` is 0 and `rd_data` is all zeros.
- R2: A rising edge of `rd_req` sampled at a clock edge produces `rd_vld` high for exactly one cycle, at the next clock edge. Holding `rd_req` high produces no further responses. `rd_data` holds its value between responses.
- R3: When `busy` is 0 in the sampling cycle, `rd_data` equals `arr_data` unchanged, so bit 7 carries the true stored value.
- R4: When `busy` is 1, `erase` is 0 and `rd_addr` equals `last_addr`, bit 7 of `rd_data` is the complement of bit 7 of `last_data`.
- R5: When `busy` is 1, `erase` is 0 and `rd_addr` differs from `last_addr`, bit 7 of `rd_data` is 0.
- R6: When `busy` and `erase` are both 1, bit 7 of `rd_data` is 0 for every address, and only the toggle bit carries status.
- R7: Every response given while busy has bits 5 down to 0 equal to 0.
- R8: The first busy response after `busy` rises has bit 6 equal to 1. Each further busy response has bit 6 inverted from the previous busy response, whatever the address.
- R9: The toggle bit advances only on a read edge. Idle cycles between polls do not change the sequence seen on bit 6.
- R10: Once `busy` falls, responses return array data and toggling stops. The next busy period starts its bit 6 sequence at 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Internal write or erase cycle in progress |
| erase | input | 1 | The busy cycle is a chip erase |
| last_addr | input | AW | Address of the last loaded byte |
| last_data | input | DW | Data of the last loaded byte |
| rd_req | input | 1 | Read request level; each rising edge is one read |
| rd_addr | input | AW | Read address |
| arr_data | input | DW | Array read data for `rd_addr` |
| rd_vld | output | 1 | One-cycle pulse marking a new response |
| rd_data | output | DW | Response byte (array data or status) |

## Verification
The bound checker enforces several rules on every response: the one-pulse-per-edge rule, array passthrough while idle, complement of bit 7 at the matching address, zero bit 7 during erase, zeroed low bits, and alternation of bit 6 within a busy run. Some behaviour can only be shown by the bench scenarios. These are: a sweep of all 256 loaded byte values, the toggle sequence continuing unchanged across long idle gaps between polls, and the restart at 1 after a busy period ends and a new one begins. The bench also covers polls at a non-matching address that are interleaved with matching ones.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [1:0] {
        RK_ARRAY       = 2'd0,
        RK_WRITE_MATCH = 2'd1,
        RK_WRITE_OTHER = 2'd2,
        RK_ERASE       = 2'd3
    } rd_kind_e;

endpackage

// File: rtl/wcs_strobe_edge.sv
module wcs_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic fire
);
    typedef struct packed {
        logic req;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = req;
        fire     = req && !st_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic advance,
    output logic tog
);
    typedef struct packed {
        logic tog;
    } tog_st_t;

    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            st_d.tog = 1'b1;
        end else if (advance) begin
            st_d.tog = !st_q.tog;
        end
        tog = st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tog: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wcs_resp_mux.sv
module wcs_resp_mux
    import wcs_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          busy,
    input  logic          erase,
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] last_addr,
    input  logic [DW-1:0] last_data,
    input  logic [DW-1:0] arr_data,
    input  logic          tog,
    output rd_kind_e      kind,
    output logic [DW-1:0] data
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;

    always_comb begin
        if (!busy) begin
            kind = RK_ARRAY;
        end else if (erase) begin
            kind = RK_ERASE;
        end else if (rd_addr == last_addr) begin
            kind = RK_WRITE_MATCH;
        end else begin
            kind = RK_WRITE_OTHER;
        end
    end

    always_comb begin
        data = '0;
        unique case (kind)
            RK_ARRAY: begin
                data = arr_data;
            end
            RK_WRITE_MATCH: begin
                data[POLL_BIT] = !last_data[POLL_BIT];
                data[TOG_BIT]  = tog;
            end
            RK_WRITE_OTHER: begin
                data[TOG_BIT]  = tog;
            end
            RK_ERASE: begin
                data[TOG_BIT]  = tog;
            end
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/wcs_status_rdout.sv
module wcs_status_rdout
    import wcs_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          erase,
    input  logic [AW-1:0] last_addr,
    input  logic [DW-1:0] last_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_data,
    output logic          rd_vld,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } out_st_t;

    out_st_t       st_d, st_q;
    logic          fire;
    logic          tog;
    rd_kind_e      kind;
    logic [DW-1:0] resp;

    wcs_strobe_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rd_req),
        .fire  (fire)
    );

    wcs_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .advance (fire && (kind != RK_ARRAY)),
        .tog     (tog)
    );

    wcs_resp_mux #(.AW(AW), .DW(DW)) u_mux (
        .busy      (busy),
        .erase     (erase),
        .rd_addr   (rd_addr),
        .last_addr (last_addr),
        .last_data (last_data),
        .arr_data  (arr_data),
        .tog       (tog),
        .kind      (kind),
        .data      (resp)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = fire;
        if (fire) begin
            st_d.data = resp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld  = st_q.vld;
    assign rd_data = st_q.data;
endmodule

// File: rtl/wcs_status_rdout_chk.sv
module wcs_status_rdout_chk #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          erase,
    input logic [AW-1:0] last_addr,
    input logic [DW-1:0] last_data,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] arr_data,
    input logic          rd_vld,
    input logic [DW-1:0] rd_data
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;

    logic req_prev_q;
    logic pend_busy_q;
    logic seen_q;
    logic last_tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev_q  <= 1'b0;
            pend_busy_q <= 1'b0;
            seen_q      <= 1'b0;
            last_tog_q  <= 1'b0;
        end else begin
            req_prev_q  <= rd_req;
            pend_busy_q <= rd_req && !req_prev_q && busy;
            if (rd_vld && pend_busy_q) begin
                seen_q     <= 1'b1;
                last_tog_q <= rd_data[TOG_BIT];
            end else if (!busy && !pend_busy_q) begin
                seen_q <= 1'b0;
            end
        end
    end

    p_vld_from_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> ($past(rd_req) && !req_prev_q == 1'b0));

    p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> !rd_vld);

    p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |-> $stable(rd_data));

    p_array_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !pend_busy_q) |-> (rd_data == $past(arr_data)));

    p_poll_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && $past(busy && !erase && (rd_addr == last_addr)))
            |-> (rd_data[POLL_BIT] == !$past(last_data[POLL_BIT])));

    p_other_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && $past(busy && !erase && (rd_addr != last_addr)))
            |-> !rd_data[POLL_BIT]);

    p_erase_bit7_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && $past(busy && erase)) |-> !rd_data[POLL_BIT]);

    p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && pend_busy_q) |-> (rd_data[TOG_BIT-1:0] == '0));

    p_first_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && pend_busy_q && !seen_q) |-> rd_data[TOG_BIT]);

    p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && pend_busy_q && seen_q) |-> (rd_data[TOG_BIT] != last_tog_q));
endmodule

bind wcs_status_rdout wcs_status_rdout_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .erase     (erase),
    .last_addr (last_addr),
    .last_data (last_data),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .arr_data  (arr_data),
    .rd_vld    (rd_vld),
    .rd_data   (rd_data)
);

// File: tb/wcs_status_rdout_test.sv
`timescale 1ns/1ps
module wcs_status_rdout_test;
    localparam int AW = 17;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy = 1'b0;
    logic          erase = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_data;
    logic          rd_vld;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic exp_tog;
    bit done = 0;

    always #2 clk = !clk;

    // array model: value computed from the address
    always_comb arr_data = DW'((rd_addr * 37 + 5) & 'hFF);

    wcs_status_rdout #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .erase(erase),
        .last_addr(last_addr), .last_data(last_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .arr_data(arr_data),
        .rd_vld(rd_vld), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one read: raise request, response one cycle later, then release
    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        rd_req  = 1'b1;
        @(negedge clk);
        chk("R2 vld", {31'd0, rd_vld}, 32'd1);
        d = rd_data;
        rd_req = 1'b0;
        @(negedge clk);
        chk("R2 single", {31'd0, rd_vld}, 32'd0);
    endtask

    function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
        return DW'((a * 37 + 5) & 'hFF);
    endfunction

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] prev;
        repeat (3) @(negedge clk);
        chk("R1 vld", {31'd0, rd_vld}, 32'd0);
        chk("R1 data", {24'd0, rd_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: idle reads return array data
        for (int i = 0; i < 64; i++) begin
            do_read(AW'(i * 1021 + 3), d);
            chk("R3", {24'd0, d}, {24'd0, arr_of(AW'(i * 1021 + 3))});
        end

        // R2: holding request high gives no more responses, data holds
        rd_addr = AW'(77);
        rd_req  = 1'b1;
        @(negedge clk);
        prev = rd_data;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 hold vld", {31'd0, rd_vld}, 32'd0);
            chk("R2 hold data", {24'd0, rd_data}, {24'd0, prev});
        end
        rd_req = 1'b0;
        @(negedge clk);

        // write busy: sweep every loaded byte value
        busy = 1'b1;
        erase = 1'b0;
        last_addr = AW'('h1_2345);
        exp_tog = 1'b1;
        for (int v = 0; v < 256; v++) begin
            last_data = DW'(v);
            do_read(last_addr, d);
            chk("R4", {31'd0, d[7]}, {31'd0, !last_data[7]});
            chk("R8", {31'd0, d[6]}, {31'd0, exp_tog});
            chk("R7", {26'd0, d[5:0]}, 32'd0);
            exp_tog = !exp_tog;
            if ((v % 16) == 5) begin
                do_read(AW'(v + 9), d);
                chk("R5", {31'd0, d[7]}, 32'd0);
                chk("R8 other", {31'd0, d[6]}, {31'd0, exp_tog});
                chk("R7 other", {26'd0, d[5:0]}, 32'd0);
                exp_tog = !exp_tog;
            end
        end

        // R9: idle gaps do not advance the toggle
        for (int g = 1; g < 12; g++) begin
            repeat (g * 3) @(negedge clk);
            do_read(last_addr, d);
            chk("R9", {31'd0, d[6]}, {31'd0, exp_tog});
            exp_tog = !exp_tog;
        end

        // R10: busy ends -> array data, true bit 7
        busy = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            do_read(last_addr + AW'(i), d);
            chk("R10 array", {24'd0, d}, {24'd0, arr_of(last_addr + AW'(i))});
        end

        // R6: erase busy, toggle restarts at 1 (R10)
        busy = 1'b1;
        erase = 1'b1;
        last_data = 8'h00;
        exp_tog = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            do_read((i % 4 == 0) ? last_addr : AW'(i * 311), d);
            if (i == 0) chk("R10 restart", {31'd0, d[6]}, 32'd1);
            chk("R6", {31'd0, d[7]}, 32'd0);
            chk("R8 erase", {31'd0, d[6]}, {31'd0, exp_tog});
            chk("R7 erase", {26'd0, d[5:0]}, 32'd0);
            exp_tog = !exp_tog;
        end
        busy = 1'b0;
        erase = 1'b0;
        @(negedge clk);
        do_read(AW'(5), d);
        chk("R10 end", {24'd0, d}, {24'd0, arr_of(AW'(5))});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule